// File: doc/BRIEF.md
# Byte Alignment Extractor

This block pulls an unaligned 32-bit word out of a 64-bit window held in two 32-bit registers, one upper word and one lower word. A 2-bit byte offset, normally the two low bits of a pointer, picks which four consecutive bytes of the eight come out. The result leaves through a single register stage, along with a valid flag.

A source-order flag swaps the two words before the bytes are picked. The upper word then supplies the low-order bytes. A streaming loop uses this to refill only one register per step. It alternates the flag so that the register holding the older data always acts as the low half of the window, and nothing has to be moved between registers.

Top module: `bae_align_top`

## Requirements
- R1: With `in_rev` = 0 and `in_ofs` = 0, the registered result equals `in_lo`.
- R2: With `in_rev` = 0, the result equals bits 31:0 of the 64-bit value {`in_hi`,`in_lo`} shifted right by 8×`in_ofs` bits. For example, `in_ofs` = 3 yields window bytes 6..3, where byte n is bits 8n+7:8n of {`in_hi`,`in_lo`}.
- R3: The lowest-numbered selected window byte sits in result bits 7:0. Each following byte sits one lane higher, so result lane j (bits 8j+7:8j) holds window byte `in_ofs`+j.
- R4: With `in_rev` = 1, the result equals bits 31:0 of {`in_lo`,`in_hi`} shifted right by 8×`in_ofs` bits. The byte selection is the same as in R2 with the two words exchanged.
- R5: With `in_rev` = 1 and `in_ofs` = 0, the result equals `in_hi`.
- R6: `out_valid` is high in the cycle after a clock edge where `in_valid` was high, and low in the cycle after an edge where it was low. `out_data` takes the new result at that same edge.
- R7: While `in_valid` is low, `out_data` holds its last value whatever the other inputs do.
- R8: A synchronous active-high `rst` clears `out_data` to 0 and `out_valid` to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe; when high, the inputs are captured at this edge |
| in_hi | input | 32 | Upper source word |
| in_lo | input | 32 | Lower source word |
| in_ofs | input | 2 | Byte offset into the 8-byte window |
| in_rev | input | 1 | Source-order flag; when high, the two words are exchanged |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_data | output | 32 | Aligned result |

## Verification
The bench sweeps all four offsets under both settings of the source-order flag. It uses random words and also a byte-index pattern, so that a lane taken from the wrong byte shows up as a wrong index value rather than as a chance match. A swap wired in the wrong direction, or a swap applied only at some offsets, gives the words back in the wrong order. Offset 3 reaches across the word boundary, so a window with an off-by-one shift would mix in the wrong boundary byte there. The bench also changes every data input while the strobe is low and checks that the held result does not follow them. It applies a reset in the middle of the run to confirm that both outputs clear.

// File: rtl/bae_pkg.sv
package bae_pkg;
    localparam int BYTE_W   = 8;
    localparam int LANES    = 4;
    localparam int WORD_W   = BYTE_W * LANES;
    localparam int OFS_W    = $clog2(LANES);
    localparam int WIN_BYTE = 2 * LANES;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [OFS_W-1:0]  ofs_t;

    typedef struct packed {
        word_t upper;
        word_t lower;
    } window_t;

    typedef struct packed {
        logic  valid;
        word_t data;
    } result_t;

    function automatic window_t order_words(input word_t hi, input word_t lo, input logic rev);
        window_t w;
        w.upper = rev ? lo : hi;
        w.lower = rev ? hi : lo;
        return w;
    endfunction
endpackage

// File: rtl/bae_order_swap.sv
module bae_order_swap
    import bae_pkg::*;
(
    input  word_t   hi_word,
    input  word_t   lo_word,
    input  logic    rev,
    output window_t win
);
    always_comb begin
        win = order_words(hi_word, lo_word, rev);
    end
endmodule

// File: rtl/bae_window_mux.sv
module bae_window_mux
    import bae_pkg::*;
(
    input  window_t win,
    input  ofs_t    ofs,
    output word_t   dout
);
    logic [WIN_BYTE*BYTE_W-1:0] flat;
    assign flat = win;

    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        logic [BYTE_W-1:0] sel;
        always_comb begin
            sel = '0;
            for (int k = 0; k < LANES; k++) begin
                if (ofs == OFS_W'(k)) begin
                    sel = flat[(lane + k) * BYTE_W +: BYTE_W];
                end
            end
        end
        assign dout[lane * BYTE_W +: BYTE_W] = sel;
    end
endmodule

// File: rtl/bae_out_stage.sv
module bae_out_stage
    import bae_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  word_t   din,
    output result_t res
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            res.valid <= load;
            if (load) begin
                res.data <= din;
            end
        end
    end
endmodule

// File: rtl/bae_align_top.sv
module bae_align_top
    import bae_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_hi,
    input  logic [WORD_W-1:0] in_lo,
    input  logic [OFS_W-1:0]  in_ofs,
    input  logic              in_rev,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);
    window_t win;
    word_t   aligned;
    result_t res;

    bae_order_swap u_swap (
        .hi_word (in_hi),
        .lo_word (in_lo),
        .rev     (in_rev),
        .win     (win)
    );

    bae_window_mux u_mux (
        .win  (win),
        .ofs  (in_ofs),
        .dout (aligned)
    );

    bae_out_stage u_out (
        .clk  (clk),
        .rst  (rst),
        .load (in_valid),
        .din  (aligned),
        .res  (res)
    );

    assign out_valid = res.valid;
    assign out_data  = res.data;
endmodule

// File: rtl/bae_align_chk.sv
module bae_align_chk
    import bae_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_hi,
    input logic [WORD_W-1:0] in_lo,
    input logic [OFS_W-1:0]  in_ofs,
    input logic              in_rev,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data
);
    AST_FWD_BASE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_rev && in_ofs == '0) |=> (out_data == $past(in_lo))); // R1
    AST_FWD_TOP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_rev && in_ofs == OFS_W'(LANES-1)) |=>
        (out_data[BYTE_W-1:0] == $past(in_lo[WORD_W-1 -: BYTE_W]))); // R2
    AST_LANE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_rev && in_ofs == OFS_W'(1)) |=>
        (out_data[WORD_W-1 -: BYTE_W] == $past(in_hi[BYTE_W-1:0]))); // R3
    AST_REV_TOP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_rev && in_ofs == OFS_W'(LANES-1)) |=>
        (out_data[BYTE_W-1:0] == $past(in_hi[WORD_W-1 -: BYTE_W]))); // R4
    AST_REV_BASE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_rev && in_ofs == '0) |=> (out_data == $past(in_hi))); // R5
    AST_VALID_SET: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R6
    AST_VALID_CLR: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R6
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data)); // R7
    AST_RESET_CLR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0)); // R8
endmodule

bind bae_align_top bae_align_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_hi     (in_hi),
    .in_lo     (in_lo),
    .in_ofs    (in_ofs),
    .in_rev    (in_rev),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/bae_align_top_tb_top.sv
module bae_align_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_hi = '0;
    logic [31:0] in_lo = '0;
    logic [1:0]  in_ofs = '0;
    logic        in_rev = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bae_align_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_hi(in_hi), .in_lo(in_lo), .in_ofs(in_ofs), .in_rev(in_rev),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [31:0] hi, input logic [31:0] lo,
                                          input logic [1:0] ofs, input logic rev);
        logic [63:0] cat;
        cat = rev ? {lo, hi} : {hi, lo};
        return 32'(cat >> (8 * ofs));
    endfunction

    // drive at a falling edge, capture at the rising edge, sample at the next falling edge
    task automatic apply(input logic [31:0] hi, input logic [31:0] lo,
                         input logic [1:0] ofs, input logic rev);
        string req;
        in_valid = 1'b1; in_hi = hi; in_lo = lo; in_ofs = ofs; in_rev = rev;
        @(negedge clk);
        if (!rev && ofs == 0)      req = "R1";
        else if (!rev)             req = "R2";
        else if (ofs == 0)         req = "R5";
        else                       req = "R4";
        check(req, out_data, model(hi, lo, ofs, rev));
        check("R6", {31'b0, out_valid}, 32'd1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R8", out_data, 32'h0);
        check("R8", {31'b0, out_valid}, 32'd0);

        // byte-index pattern: lane j must hold index ofs+j
        for (int r = 0; r < 2; r++) begin
            for (int o = 0; o < 4; o++) begin
                logic [31:0] e;
                apply(32'h07060504, 32'h03020100, 2'(o), r[0]);
                for (int j = 0; j < 4; j++) begin
                    e[8*j +: 8] = 8'((o + j + (r ? 4 : 0)) % 8);
                end
                check("R3", out_data, e);
            end
        end

        // random sweep over every offset and order
        for (int n = 0; n < 48; n++) begin
            for (int r = 0; r < 2; r++) begin
                for (int o = 0; o < 4; o++) begin
                    apply($urandom, $urandom, 2'(o), r[0]);
                end
            end
        end

        // streaming: alternate order, reload one word per step
        for (int s = 0; s < 16; s++) begin
            if (s[0]) apply(in_hi, $urandom, 2'(s), 1'b1);
            else      apply($urandom, in_lo, 2'(s), 1'b0);
        end

        // hold with strobe low, inputs toggling
        held = out_data;
        for (int n = 0; n < 6; n++) begin
            in_valid = 1'b0; in_hi = $urandom; in_lo = $urandom;
            in_ofs = 2'(n); in_rev = n[0];
            @(negedge clk);
            check("R7", out_data, held);
            check("R6", {31'b0, out_valid}, 32'd0);
        end

        // reset mid-run
        apply(32'hdeadbeef, 32'hcafef00d, 2'd2, 1'b0);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R8", out_data, 32'h0);
        check("R8", {31'b0, out_valid}, 32'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        summary();
    end
endmodule